// File: doc/BRIEF.md
# Modulo Data Address Generator

This block produces data-memory addresses for a signal-processing datapath. It keeps a bank of four index pointers. Beside them it keeps four signed modify registers, four length registers and four base registers. An access request names one pointer and one modify register. The block puts that pointer's present value on the address output, one clock later, with a valid strobe. In the same clock edge it steps the pointer by the chosen modify amount.

When the length register paired with the pointer is zero, the step is a plain wrap-around add in the address width. When the length is nonzero, the block keeps the stepped pointer inside a circular buffer. That buffer starts at the pointer's base and holds length words, so filter delay lines and tables can be walked with no wrap code in the program.

A datapath that fetches two operands per cycle uses two instances side by side. All four register kinds are loaded through one write port that selects the kind and the entry.

Top module: `modaddr_gen`

## Requirements
- R1: After reset every index, modify, length and base register reads as zero, and `addr_vld` is low.
- R2: A request sampled high at a clock edge makes `addr_vld` high for the following cycle only. In that cycle `addr_out` equals the selected pointer's value from before the edge. With no request, `addr_vld` is low in the following cycle.
- R3: With the pointer's length equal to 0, a request replaces the pointer with pointer + modify, taken modulo 2^14. For example, 16383 + 1 gives 0.
- R4: Modify registers hold signed two's-complement 14-bit values. For example, 14'h3FFD steps the pointer by -3.
- R5: With length L nonzero and base B, and with the pointer inside [B, B+L), |modify| < L and B+L <= 2^14, a request leaves the pointer at B + ((pointer - B + modify) mod L). This holds for both signs of modify.
- R6: When an index write and a request name the same pointer in one cycle, `addr_out` shows the old value, and the written value replaces the post-modify result.
- R7: The write kind selects the register bank: 0 = index, 1 = modify, 2 = length, 3 = base. `wr_sel` picks the entry. A write of any kind never raises `addr_vld`.
- R8: A request changes only the selected pointer. The other three pointers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Bank select: 0 index, 1 modify, 2 length, 3 base |
| wr_sel | input | 2 | Entry within the bank |
| wr_data | input | 14 | Write value |
| acc_req | input | 1 | Access request |
| acc_ptr | input | 2 | Pointer used for the access |
| acc_mod | input | 2 | Modify register used for the step |
| addr_out | output | 14 | Address of the access, registered |
| addr_vld | output | 1 | High for one cycle per access |

## Verification
A wrong pointer update stays hidden until the next access to the same pointer. At that point `addr_out` shows the error, one cycle after the request. The bench therefore walks every pointer again and again, so that a bad step, a wrong wrap or a lost collision write shows up within a few accesses. A wrong bank decode or a leak between pointers shows up the same way, on the next access that uses the damaged register. Faults in the strobe show at once, in the cycle after any request or write.

// File: rtl/dag_pkg.sv
package dag_pkg;
  typedef enum logic [1:0] {
    KIND_INDEX  = 2'd0,
    KIND_MODIFY = 2'd1,
    KIND_LENGTH = 2'd2,
    KIND_BASE   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/dag_regbank.sv
module dag_regbank #(
  parameter int AW = 14,
  parameter int N  = 4,
  localparam int SW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_sel,
  input  logic [AW-1:0]        wr_data,
  input  logic                 upd_en,
  input  logic [SW-1:0]        upd_sel,
  input  logic [AW-1:0]        upd_val,
  output logic [N-1:0][AW-1:0] q
);
  // one register per entry; a write beats an update to the same entry
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic hit_wr, hit_up;
    assign hit_wr = wr_en && (wr_sel == SW'(g));
    assign hit_up = upd_en && (upd_sel == SW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[g] <= '0;
      else if (hit_wr) q[g] <= wr_data;
      else if (hit_up) q[g] <= upd_val;
    end
  end
endmodule

// File: rtl/dag_update.sv
module dag_update #(
  parameter int AW = 14,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] step,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] next
);
  // post-modify with optional circular wrap, done in a wider signed field
  function automatic logic [AW-1:0] step_ptr(
    input logic [AW-1:0] p, input logic [AW-1:0] m,
    input logic [AW-1:0] l, input logic [AW-1:0] b);
    logic signed [EW-1:0] sum, lo, hi;
    sum = $signed({2'b00, p}) + $signed({{2{m[AW-1]}}, m});
    lo  = $signed({2'b00, b});
    hi  = lo + $signed({2'b00, l});
    if (l != '0) begin
      if (sum < lo)       sum = sum + $signed({2'b00, l});
      else if (sum >= hi) sum = sum - $signed({2'b00, l});
    end
    return sum[AW-1:0];
  endfunction

  assign next = step_ptr(cur, step, len, base);
endmodule

// File: rtl/modaddr_gen.sv
module modaddr_gen #(
  parameter int AW = 14,
  parameter int N  = 4,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [SW-1:0] wr_sel,
  input  logic [AW-1:0] wr_data,
  input  logic          acc_req,
  input  logic [SW-1:0] acc_ptr,
  input  logic [SW-1:0] acc_mod,
  output logic [AW-1:0] addr_out,
  output logic          addr_vld
);
  import dag_pkg::*;

  logic [N-1:0][AW-1:0] idx_q, mod_q, len_q, base_q;
  logic                 we_idx, we_mod, we_len, we_base;
  // named internal events for the checker
  logic                 upd_fire;
  logic [AW-1:0]        cur_idx, cur_mod, cur_len, cur_base, upd_next;

  assign we_idx  = wr_en && (wr_kind_e'(wr_kind) == KIND_INDEX);
  assign we_mod  = wr_en && (wr_kind_e'(wr_kind) == KIND_MODIFY);
  assign we_len  = wr_en && (wr_kind_e'(wr_kind) == KIND_LENGTH);
  assign we_base = wr_en && (wr_kind_e'(wr_kind) == KIND_BASE);

  assign upd_fire = acc_req;
  assign cur_idx  = idx_q[acc_ptr];
  assign cur_len  = len_q[acc_ptr];
  assign cur_base = base_q[acc_ptr];
  assign cur_mod  = mod_q[acc_mod];

  dag_regbank #(.AW(AW), .N(N)) u_idx (
    .clk(clk), .rst_n(rst_n), .wr_en(we_idx), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(upd_fire), .upd_sel(acc_ptr), .upd_val(upd_next), .q(idx_q));
  dag_regbank #(.AW(AW), .N(N)) u_mod (
    .clk(clk), .rst_n(rst_n), .wr_en(we_mod), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(1'b0), .upd_sel('0), .upd_val('0), .q(mod_q));
  dag_regbank #(.AW(AW), .N(N)) u_len (
    .clk(clk), .rst_n(rst_n), .wr_en(we_len), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(1'b0), .upd_sel('0), .upd_val('0), .q(len_q));
  dag_regbank #(.AW(AW), .N(N)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(we_base), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_en(1'b0), .upd_sel('0), .upd_val('0), .q(base_q));

  dag_update #(.AW(AW)) u_upd (
    .cur(cur_idx), .step(cur_mod), .len(cur_len), .base(cur_base), .next(upd_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_out <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= acc_req;
      if (acc_req) addr_out <= cur_idx;
    end
  end
endmodule

// File: rtl/modaddr_gen_chk.sv
module modaddr_gen_chk #(
  parameter int AW = 14,
  parameter int N  = 4,
  localparam int SW = $clog2(N)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_req,
  input logic [SW-1:0]        acc_ptr,
  input logic                 addr_vld,
  input logic                 we_idx,
  input logic                 wr_en,
  input logic [SW-1:0]        wr_sel,
  input logic [AW-1:0]        wr_data,
  input logic                 upd_fire,
  input logic [AW-1:0]        cur_idx,
  input logic [AW-1:0]        cur_mod,
  input logic [AW-1:0]        cur_len,
  input logic [AW-1:0]        cur_base,
  input logic [AW-1:0]        upd_next,
  input logic [N-1:0][AW-1:0] idx_q
);
  logic [AW+1:0] lo_w, hi_w, nx_w, cur_w;
  logic [AW-1:0] mag;
  assign lo_w  = {2'b00, cur_base};
  assign hi_w  = {2'b00, cur_base} + {2'b00, cur_len};
  assign nx_w  = {2'b00, upd_next};
  assign cur_w = {2'b00, cur_idx};
  assign mag   = cur_mod[AW-1] ? (~cur_mod + 1'b1) : cur_mod;

  // R2: a request yields a strobe in the next cycle
  a_r2_vld_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> addr_vld);
  // R2/R7: no request, no strobe
  a_r7_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> !addr_vld);
  // R5: a legal circular step stays inside its buffer
  a_r5_wrap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && cur_len != '0 && cur_w >= lo_w && cur_w < hi_w &&
     mag < cur_len && hi_w <= (1 << AW)) |-> (nx_w >= lo_w && nx_w < hi_w));
  // R3: zero length gives a linear step
  a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_fire && cur_len == '0) |-> (upd_next == AW'(cur_idx + cur_mod)));
  // R6: an index write beats the update on a collision
  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (we_idx && acc_req && wr_sel == acc_ptr) |=> (idx_q[$past(wr_sel)] == $past(wr_data)));
  // R8: pointers not named by the request or a write keep their value
  for (genvar g = 0; g < N; g++) begin : g_hold
    a_r8_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(acc_req && acc_ptr == SW'(g)) && !(we_idx && wr_sel == SW'(g)))
        |=> $stable(idx_q[g]));
  end
  logic unused_ok;
  assign unused_ok = wr_en;
endmodule

bind modaddr_gen modaddr_gen_chk #(.AW(AW), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_ptr(acc_ptr),
  .addr_vld(addr_vld), .we_idx(we_idx), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .upd_fire(upd_fire), .cur_idx(cur_idx), .cur_mod(cur_mod),
  .cur_len(cur_len), .cur_base(cur_base), .upd_next(upd_next), .idx_q(idx_q));

// File: tb/test_modaddr_gen.sv
module test_modaddr_gen;
  localparam int AW = 14;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, acc_req = 1'b0;
  logic [1:0] wr_kind = '0, wr_sel = '0, acc_ptr = '0, acc_mod = '0;
  logic [AW-1:0] wr_data = '0;
  logic [AW-1:0] addr_out;
  logic addr_vld;

  int checks = 0, errors = 0;
  int m_idx[4], m_mod[4], m_len[4], m_base[4];

  always #10 clk = ~clk;

  modaddr_gen i_modaddr_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_sel(wr_sel),
    .wr_data(wr_data), .acc_req(acc_req), .acc_ptr(acc_ptr), .acc_mod(acc_mod),
    .addr_out(addr_out), .addr_vld(addr_vld));

  function automatic int sx(input int v);
    return (v & (1 << (AW - 1))) ? (v & MASK) - (1 << AW) : (v & MASK);
  endfunction

  // offset arithmetic with a true modulo, independent of the RTL form
  function automatic int next_ptr(input int p, input int m, input int l, input int b);
    int off;
    if (l == 0) return (p + sx(m)) & MASK;
    off = p - b + sx(m);
    off = ((off % l) + l) % l;
    return (b + off) & MASK;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called just after a negative edge; checks at the following negative edge
  task automatic step(input bit req, input int p, input int m, input bit we,
                      input int kind, input int sel, input int data, input string tag);
    int exp_addr;
    acc_req = req; acc_ptr = 2'(p); acc_mod = 2'(m);
    wr_en = we; wr_kind = 2'(kind); wr_sel = 2'(sel); wr_data = AW'(data);
    exp_addr = m_idx[p];
    if (req) m_idx[p] = next_ptr(m_idx[p], m_mod[m], m_len[p], m_base[p]);
    if (we) begin
      case (kind)
        0: m_idx[sel] = data & MASK;
        1: m_mod[sel] = data & MASK;
        2: m_len[sel] = data & MASK;
        default: m_base[sel] = data & MASK;
      endcase
    end
    @(negedge clk);
    acc_req = 1'b0; wr_en = 1'b0;
    chk({tag, " vld"}, int'(addr_vld), int'(req));
    if (req) chk({tag, " addr"}, int'(addr_out), exp_addr);
  endtask

  task automatic wr(input int kind, input int sel, input int data, input string tag);
    step(1'b0, 0, 0, 1'b1, kind, sel, data, tag);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 4; k++) begin
      m_idx[k] = 0; m_mod[k] = 0; m_len[k] = 0; m_base[k] = 0;
    end
    repeat (3) @(negedge clk);
    chk("R1 reset vld", int'(addr_vld), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: registers start at zero
    for (int k = 0; k < 4; k++) step(1'b1, k, k, 1'b0, 0, 0, 0, "R1 reset pointer");

    // R3: linear wrap at the top of the address space
    wr(0, 0, 16383, "R7 write index");
    wr(1, 0, 1, "R7 write modify");
    step(1'b1, 0, 0, 1'b0, 0, 0, 0, "R3 linear top");
    step(1'b1, 0, 0, 1'b0, 0, 0, 0, "R3 linear wrapped");

    // R4: negative modify
    wr(0, 1, 10, "R7 write index");
    wr(1, 1, 16381, "R4 write modify -3");
    step(1'b1, 1, 1, 1'b0, 0, 0, 0, "R4 negative step a");
    step(1'b1, 1, 1, 1'b0, 0, 0, 0, "R4 negative step b");

    // R5: circular buffer, both directions
    wr(3, 2, 100, "R7 write base");
    wr(2, 2, 10, "R7 write length");
    wr(0, 2, 108, "R7 write index");
    wr(1, 2, 3, "R7 write modify");
    wr(1, 3, 16380, "R7 write modify -4");
    step(1'b1, 2, 2, 1'b0, 0, 0, 0, "R5 up step");
    step(1'b1, 2, 3, 1'b0, 0, 0, 0, "R5 wrapped high");
    step(1'b1, 2, 3, 1'b0, 0, 0, 0, "R5 wrapped low");

    // R6: collision write beats the update
    step(1'b1, 2, 2, 1'b1, 0, 2, 555, "R6 collision old addr");
    step(1'b1, 2, 0, 1'b0, 0, 0, 0, "R6 collision new value");

    // R8: other pointer untouched by accesses to pointer 1
    step(1'b1, 1, 1, 1'b0, 0, 0, 0, "R8 other access");
    step(1'b1, 0, 0, 1'b0, 0, 0, 0, "R8 pointer 0 kept");

    // R7: writes alone never strobe
    wr(2, 3, 0, "R7 write no strobe");
    step(1'b0, 0, 0, 1'b0, 0, 0, 0, "R2 idle");

    // random phase: legal buffers, small modify values
    for (int k = 0; k < 4; k++) begin
      int l, b;
      l = ($urandom % 4 == 0) ? 0 : 8 + int'($urandom % 200);
      b = int'($urandom % (16000 - l));
      wr(2, k, l, "R7 rnd length");
      wr(3, k, b, "R7 rnd base");
      wr(0, k, (l == 0) ? int'($urandom % 16384) : b + int'($urandom % l), "R7 rnd index");
      wr(1, k, (int'($urandom % 15) - 7) & MASK, "R4 rnd modify");
    end
    for (int n = 0; n < 3000; n++) begin
      int p, m, s, v;
      bit we;
      p = int'($urandom % 4); m = int'($urandom % 4);
      we = ($urandom % 10 == 0);
      s = int'($urandom % 4);
      v = (m_len[s] == 0) ? int'($urandom % 16384) : m_base[s] + int'($urandom % m_len[s]);
      step(($urandom % 10) < 7, p, m, we, 0, s, v,
           (m_len[p] == 0) ? "R3 rnd linear" : "R5 rnd circular");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule